// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition-Flag Update

This block shifts or rotates a source operand of 1, 2, 4 or 8 bytes, merges the sized result into the previous destination value, and updates a five-bit condition-flag word. Seven operations are supported: logical left, logical right, arithmetic right, plain rotate right and left, and rotate right and left through the carry flag. The shift count is reduced to an effective count that depends on the operand size. A per-operation enable mask selects which flags may change. When the effective count is zero, no flag changes.

All the shifting, flag and merge logic is combinational. The result and the flag word are captured in one output register, so both outputs are valid on the clock edge after the inputs are presented. An execution pipeline uses the block by presenting one operation per cycle and reading the registered outputs one cycle later.

Top module: `shrot_unit`

## Requirements
- R1: The effective count is `count_i[5:0]` when `size_i` is 3 (8 bytes) and `count_i[4:0]` otherwise; higher count bits have no effect. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: With an effective count of zero, `flags_o` equals `flags_i`. The rotate operations (codes 3 to 6) then return `dest_i` unchanged, and the shifts (codes 0 to 2) return the source merged by size.
- R3: Flag bits are carry [0], overflow [1], zero [2], sign [3] and parity [4]. Bits with a clear `mask_i` bit never change. For a nonzero count, each enabled bit is cleared and then set only when its condition holds.
- R4: Left shift (op 0) fills with zeros. Its carry is source bit (W−n), or 0 when n > W. Its overflow is that carry XOR the result's top bit (W = operand width in bits, n = effective count).
- R5: Logical right shift (op 1) fills with zeros and arithmetic right shift (op 2) fills with the sign bit. For both, carry is source bit (n−1), or the fill value when n > W. Overflow is the source's top bit for op 1 and is always 0 for op 2.
- R6: Rotate right (op 3) and rotate left (op 4) rotate by n mod W. For rotate right, carry is the result's top bit and overflow is the XOR of its two top bits. For rotate left, carry is the result's bit 0 and overflow is its top bit XOR its bit 0.
- R7: Rotate right through carry (op 5) and rotate left through carry (op 6) rotate the (W+1)-bit ring {carry, source} by n mod (W+1). For op 5, overflow is the old carry XOR the source's top bit. For op 6, overflow is the result's top bit XOR the new carry.
- R8: For sizes of 1 and 2 bytes, bits of `dest_i` above the operand width pass through to `res_o`. For sizes of 4 and 8 bytes, the sized result is zero-extended to 64 bits.
- R9: Zero is set for an all-zero sized result, and sign is the sized result's top bit. Parity is set when the result's low byte holds an even number of ones.
- R10: Op code 7 is a no-operation: `res_o` equals `dest_i` and `flags_o` equals `flags_i`.
- R11: Outputs are registered, one cycle after the inputs. A synchronous active-low reset clears `res_o` and `flags_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (0..6, 7 = no-operation) |
| size_i | input | 2 | Operand size code |
| count_i | input | 8 | Raw shift count |
| src_i | input | 64 | Source operand |
| dest_i | input | 64 | Previous destination value |
| flags_i | input | 5 | Incoming flag word (carry in bit 0) |
| mask_i | input | 5 | Per-flag update enable |
| res_o | output | 64 | Merged result, registered |
| flags_o | output | 5 | Updated flag word, registered |

## Verification
On every cycle, the assertions check the flag rules and the merge and reset rules. The flag rules are: flags never change for a zero effective count, masked-off flags never change, and arithmetic right shift never sets overflow. The merge and reset rules are: upper destination bits are kept for 1-byte operands, the no-operation code holds the destination, and reset clears the outputs. The actual bit values are shown only by the bench's scenarios: the shifted and rotated results, the carry and overflow conditions of each operation, count wrap in the rotates, and the zero/sign/parity values.

// File: rtl/shrot_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the shift/rotate unit.
// Assumes a 64-bit register file and a five-bit flag word.
package shrot_pkg;
    localparam int REG_W  = 64;
    localparam int CNT_W  = 8;
    localparam int FLAG_W = 5;
    localparam int N_SIZE = 4;
    localparam int ECW    = $clog2(REG_W);   // effective count width

    localparam int FB_C = 0;
    localparam int FB_O = 1;
    localparam int FB_Z = 2;
    localparam int FB_S = 3;
    localparam int FB_P = 4;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROTR = 3'd3,
        OP_ROTL = 3'd4,
        OP_RCAR = 3'd5,
        OP_RCAL = 3'd6,
        OP_HOLD = 3'd7
    } shop_e;
endpackage

// File: rtl/shrot_lane.sv
`timescale 1ns/1ps
// One operand-width lane: computes the shifted/rotated value and the raw
// carry and overflow conditions for a fixed width W.
// Assumes cnt is already the effective count; counts beyond W are legal.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic [W-1:0]  src,
    input  logic [CW-1:0] cnt,
    input  logic          cin,
    input  shop_e         op,
    output logic [W-1:0]  res,
    output logic          cf_c,
    output logic          of_c
);
    localparam int AW = $clog2(W);
    localparam int RW = W + 1;
    localparam int MW = CW + 1;

    logic [2*W-1:0]         shl_w, shr_w, rot_r, rot_l;
    logic signed [2*W-1:0]  sar_w;
    logic [AW-1:0]          ramt;
    logic [MW-1:0]          ramt_c;
    logic [RW-1:0]          ring;
    logic [2*RW-1:0]        rc_r, rc_l;

    assign shl_w = {{W{1'b0}}, src} << cnt;
    assign shr_w = {src, {W{1'b0}}} >> cnt;
    assign sar_w = $signed({src, {W{1'b0}}}) >>> cnt;
    assign ramt  = cnt[AW-1:0];
    assign rot_r = {src, src} >> ramt;
    assign rot_l = {src, src} << ramt;
    assign ring  = {cin, src};
    assign rc_r  = {ring, ring} >> ramt_c;
    assign rc_l  = {ring, ring} << ramt_c;

    // Reduce the count modulo the (W+1)-bit carry ring.
    always_comb begin
        ramt_c = {1'b0, cnt};
        for (int k = 0; k < 4; k++) begin
            if (ramt_c >= MW'(RW)) ramt_c = ramt_c - MW'(RW);
        end
    end

    // Select result and carry/overflow conditions per operation.
    always_comb begin
        res  = src;
        cf_c = 1'b0;
        of_c = 1'b0;
        case (op)
            OP_SHL: begin
                res  = shl_w[W-1:0];
                cf_c = shl_w[W];
                of_c = shl_w[W] ^ shl_w[W-1];
            end
            OP_SHR: begin
                res  = shr_w[2*W-1:W];
                cf_c = shr_w[W-1];
                of_c = src[W-1];
            end
            OP_SAR: begin
                res  = sar_w[2*W-1:W];
                cf_c = sar_w[W-1];
                of_c = 1'b0;
            end
            OP_ROTR: begin
                res  = rot_r[W-1:0];
                cf_c = rot_r[W-1];
                of_c = rot_r[W-1] ^ rot_r[W-2];
            end
            OP_ROTL: begin
                res  = rot_l[2*W-1:W];
                cf_c = rot_l[W];
                of_c = rot_l[2*W-1] ^ rot_l[W];
            end
            OP_RCAR: begin
                res  = rc_r[W-1:0];
                cf_c = rc_r[W];
                of_c = cin ^ src[W-1];
            end
            OP_RCAL: begin
                res  = rc_l[RW+W-1:RW];
                cf_c = rc_l[2*RW-1];
                of_c = rc_l[RW+W-1] ^ rc_l[2*RW-1];
            end
            default: begin
                res  = src;
                cf_c = 1'b0;
                of_c = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
`timescale 1ns/1ps
// Flag update: clears the enabled flags, then sets those whose condition
// holds. Leaves the word untouched when upd is low.
// Assumes res_z is the sized result zero-extended to REG_W bits.
module shrot_flags
    import shrot_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [FLAG_W-1:0] mask,
    input  logic              upd,
    input  logic [REG_W-1:0]  res_z,
    input  logic              sf_c,
    input  logic              cf_c,
    input  logic              of_c,
    output logic [FLAG_W-1:0] flags_out
);
    logic [FLAG_W-1:0] cond;

    // Gather the five flag conditions in flag-word order.
    always_comb begin
        cond       = '0;
        cond[FB_C] = cf_c;
        cond[FB_O] = of_c;
        cond[FB_Z] = (res_z == '0);
        cond[FB_S] = sf_c;
        cond[FB_P] = ~^res_z[7:0];
    end

    // Clear-then-set the enabled flags when an update is due.
    always_comb begin
        if (upd) flags_out = (flags_in & ~mask) | (cond & mask);
        else     flags_out = flags_in;
    end
endmodule

// File: rtl/shrot_unit.sv
`timescale 1ns/1ps
// Shift/rotate unit top: derives the effective count, runs one lane per
// operand size, merges the chosen lane into the destination and registers
// result and flags. Assumes a synchronous active-low reset.
module shrot_unit
    import shrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [REG_W-1:0]  src_i,
    input  logic [REG_W-1:0]  dest_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] mask_i,
    output logic [REG_W-1:0]  res_o,
    output logic [FLAG_W-1:0] flags_o
);
    shop_e             op;
    logic [ECW-1:0]    eff_cnt;
    logic              cnt_nz;
    logic              is_rot;
    logic              hold;
    logic [REG_W-1:0]  lane_res [N_SIZE];
    logic [N_SIZE-1:0] lane_cf, lane_of, lane_msb;
    logic [REG_W-1:0]  sel_res, merged, res_d;
    logic [FLAG_W-1:0] flags_d;

    assign op = shop_e'(op_i);

    // Effective count: six bits for 8-byte operands, five otherwise.
    always_comb begin
        if (size_i == 2'd3) eff_cnt = count_i[ECW-1:0];
        else                eff_cnt = {1'b0, count_i[ECW-2:0]};
    end

    assign cnt_nz = (eff_cnt != '0);
    assign is_rot = (op == OP_ROTR) || (op == OP_ROTL) ||
                    (op == OP_RCAR) || (op == OP_RCAL);
    assign hold   = (op == OP_HOLD) || (is_rot && !cnt_nz);

    for (genvar g = 0; g < N_SIZE; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] lres;
        shrot_lane #(.W(LW), .CW(ECW)) u_lane (
            .src  (src_i[LW-1:0]),
            .cnt  (eff_cnt),
            .cin  (flags_i[FB_C]),
            .op   (op),
            .res  (lres),
            .cf_c (lane_cf[g]),
            .of_c (lane_of[g])
        );
        assign lane_res[g] = REG_W'(lres);
        assign lane_msb[g] = lres[LW-1];
    end

    assign sel_res = lane_res[size_i];

    // Merge the sized result into the old destination.
    always_comb begin
        case (size_i)
            2'd0:    merged = {dest_i[REG_W-1:8],  sel_res[7:0]};
            2'd1:    merged = {dest_i[REG_W-1:16], sel_res[15:0]};
            default: merged = sel_res;
        endcase
        res_d = hold ? dest_i : merged;
    end

    shrot_flags u_flags (
        .flags_in  (flags_i),
        .mask      (mask_i),
        .upd       (cnt_nz && (op != OP_HOLD)),
        .res_z     (sel_res),
        .sf_c      (lane_msb[size_i]),
        .cf_c      (lane_cf[size_i]),
        .of_c      (lane_of[size_i]),
        .flags_out (flags_d)
    );

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            flags_o <= '0;
        end else begin
            res_o   <= res_d;
            flags_o <= flags_d;
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
`timescale 1ns/1ps
// Checker bound to shrot_unit: port-level properties of the flag and
// merge rules. Assumes the one-cycle output register of the top.
module shrot_unit_chk
    import shrot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [1:0]        size_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [REG_W-1:0]  dest_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [FLAG_W-1:0] mask_i,
    input logic [REG_W-1:0]  res_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic primed;
    logic eff_zero;

    // Marks that a full non-reset cycle has gone by.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assign eff_zero = (size_i == 2'd3) ? (count_i[5:0] == 6'd0)
                                       : (count_i[4:0] == 5'd0);

    assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(eff_zero) |-> flags_o == $past(flags_i));

    assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ((flags_o ^ $past(flags_i)) & ~$past(mask_i)) == '0);

    assert_sar_no_of_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 3'd2 && $past(mask_i[1]) && !$past(eff_zero)
        |-> !flags_o[1]);

    assert_byte_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(size_i) == 2'd0 |-> res_o[REG_W-1:8] == $past(dest_i[REG_W-1:8]));

    assert_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 3'd7 |-> res_o == $past(dest_i));

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && flags_o == '0));
endmodule

bind shrot_unit shrot_unit_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .size_i  (size_i),
    .count_i (count_i),
    .dest_i  (dest_i),
    .flags_i (flags_i),
    .mask_i  (mask_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
// Bench for shrot_unit: a table of vectors walked by one loop, then
// directed reset checks.
module test_shrot_unit;
    localparam logic [63:0] D  = 64'hAAAA_AAAA_AAAA_AAAA;
    localparam int          NV = 19;
    localparam int          VW = 220;

    // {op, size, count, flags_in, mask, src, dest, exp_res, exp_flags}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd0, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA02, 5'h03},
        {3'd1, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA40, 5'h03},
        {3'd2, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AAC0, 5'h19},
        {3'd3, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AAC0, 5'h19},
        {3'd4, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA03, 5'h13},
        {3'd5, 2'd0, 8'd1,    5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA40, 5'h03},
        {3'd6, 2'd0, 8'd1,    5'h01, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA03, 5'h13},
        {3'd0, 2'd0, 8'd0,    5'h0A, 5'h1F, 64'h55, D, 64'hAAAA_AAAA_AAAA_AA55, 5'h0A},
        {3'd3, 2'd1, 8'd0,    5'h15, 5'h1F, 64'h1234, D, D, 5'h15},
        {3'd0, 2'd0, 8'h21,   5'h00, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA02, 5'h03},
        {3'd0, 2'd3, 8'h41,   5'h00, 5'h1F, 64'h8000_0000_0000_0001, D, 64'h2, 5'h03},
        {3'd1, 2'd2, 8'd31,   5'h00, 5'h1F, 64'hFFFF_FFFF_8000_0000, D, 64'h1, 5'h02},
        {3'd0, 2'd0, 8'd1,    5'h1E, 5'h01, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA02, 5'h1F},
        {3'd0, 2'd0, 8'd1,    5'h02, 5'h00, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA02, 5'h02},
        {3'd0, 2'd1, 8'd1,    5'h00, 5'h1F, 64'h8000, D, 64'hAAAA_AAAA_AAAA_0000, 5'h17},
        {3'd6, 2'd0, 8'd9,    5'h01, 5'h1F, 64'h81, D, 64'hAAAA_AAAA_AAAA_AA81, 5'h19},
        {3'd3, 2'd1, 8'd16,   5'h00, 5'h1F, 64'h8001, D, 64'hAAAA_AAAA_AAAA_8001, 5'h0B},
        {3'd7, 2'd0, 8'd1,    5'h0A, 5'h1F, 64'h81, D, D, 5'h0A},
        {3'd2, 2'd0, 8'd20,   5'h00, 5'h1F, 64'h80, D, 64'hAAAA_AAAA_AAAA_AAFF, 5'h19}
    };
    localparam logic [23:0] TAG [NV] = '{
        "R4 ", "R5 ", "R5 ", "R6 ", "R6 ", "R7 ", "R7 ", "R2 ", "R2 ", "R1 ",
        "R1 ", "R8 ", "R3 ", "R3 ", "R9 ", "R7 ", "R6 ", "R10", "R5 "
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [7:0]  count_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] dest_i = '0;
    logic [4:0]  flags_i = '0;
    logic [4:0]  mask_i = '0;
    logic [63:0] res_o;
    logic [4:0]  flags_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    shrot_unit i_shrot_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .count_i(count_i), .src_i(src_i), .dest_i(dest_i),
        .flags_i(flags_i), .mask_i(mask_i), .res_o(res_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input logic [63:0] er, input logic [4:0] ef);
        n_chk++;
        if (res_o !== er || flags_o !== ef) begin
            n_bad++;
            $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h",
                     req, res_o, flags_o, er, ef);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", 64'h0, 5'h00);        // reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            {op_i, size_i, count_i, flags_i, mask_i, src_i, dest_i} = v[219:69];
            @(negedge clk);
            check(string'(TAG[i]), v[68:5], v[4:0]);
        end
        // R11: reset mid-run with live inputs clears the outputs
        op_i = 3'd0; size_i = 2'd3; count_i = 8'd1; src_i = 64'hFF;
        flags_i = 5'h1F; mask_i = 5'h1F; rst_n = 1'b0;
        @(negedge clk);
        check("R11", 64'h0, 5'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 64'h1FE, 5'h00);     // R4 after reset: 0xFF<<1, pf set? low byte FE has 7 ones
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule